// File: doc/BRIEF.md
# Breathing Brightness Ramp Sequencer

This block produces a brightness word that climbs one count at a time from a lower bound to an upper bound and then descends back, over and over, forming a triangle wave. A downstream pulse-width stage turns that word into LED drive, so the light swells and fades continuously. How the pulse stage interprets the word is not this block's concern. The block supplies only the value and the present direction of travel.

The pace of the ramp is set by a prescaler that runs on the main clock. The prescaler counts up to a run-time divide value `step_div`, restarts from zero and issues a one-cycle step enable. No derived slow clock is used. Only cycles that carry that enable move the brightness word. With divide value D the word moves once every D+1 clock cycles. A divide value in the millions gives steps a few milliseconds apart.

A two-state machine tracks direction. The states are `ST_RISE` and `ST_FALL`, and there are two transitions:
- `ST_RISE` goes to `ST_FALL` on the step that lands on the upper bound.
- `ST_FALL` goes to `ST_RISE` on the step that lands on the lower bound.

Because the turn happens on the landing step, each bound value is shown for exactly one step interval, and no value is repeated at a turn. The bounds are elaboration parameters, and the lower bound must be strictly below the upper bound.

Top module: `breath_ramp`

## Requirements
- R1: While reset is asserted, `level` equals LVL_LO and `rising` is 1. The prescaler is cleared, so the first change of `level` after reset release is made by rising clock edge D+2 (edges counted from the release), where D is `step_div`.
- R2: `level` changes exactly once every D+1 clock cycles and holds its value on all other cycles; D = 0 gives a change on every cycle.
- R3: Each change moves `level` by exactly one count, upward while `rising` = 1 and downward while `rising` = 0.
- R4: The step that brings `level` to LVL_HI also sets `rising` to 0 (state `ST_FALL`). The next step gives LVL_HI-1.
- R5: The step that brings `level` to LVL_LO also sets `rising` to 1 (state `ST_RISE`). The next step gives LVL_LO+1.
- R6: `level` never leaves the closed range LVL_LO to LVL_HI.
- R7: The sequence repeats indefinitely with a period of 2*(LVL_HI-LVL_LO) steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_div | input | DIV_W | Divide value D; one step every D+1 cycles |
| level | output | LVL_W | Brightness word for the pulse-width stage |
| rising | output | 1 | Direction: 1 = counting up, 0 = counting down |

## Verification
With divide value D, the prescaler flags its first enable after edge D+1 from reset release. `level` therefore first moves on edge D+2, and then on every further D+1 edges. For the result after edge e, the bench computes the step count as floor((e-1)/(D+1)). It maps that count through the triangle arithmetic to an expected `level` and `rising`. It samples on the falling edge after each rising edge, so each comparison falls between the register update and the next edge. This sweep runs for several divide values, each over more than two full triangle periods. Each sweep ends partway down a falling ramp, so the reset that starts the next sweep also exercises reset mid-run.

// File: rtl/breath_pkg.sv
package breath_pkg;

    typedef enum logic {
        ST_RISE = 1'b0,
        ST_FALL = 1'b1
    } ramp_state_t;

endpackage

// File: rtl/breath_tick.sv
module breath_tick #(
    parameter int DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    // Restart when the count reaches (or passes) the divide value.
    assign wrap = (cnt_q >= div_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            if (wrap) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + DIV_W'(1);
            end
            tick <= wrap;
        end
    end

    // R2: a non-zero divide value never yields two back-to-back enables
    a_r2_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (div_val != '0) && $stable(div_val)) |=> !tick);

    // R2: with a steady divide value the count stays within it
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(div_val) |=> (cnt_q <= div_val));

endmodule

// File: rtl/breath_seq.sv
module breath_seq
    import breath_pkg::*;
#(
    parameter int LVL_W  = 8,
    parameter int LVL_LO = 0,
    parameter int LVL_HI = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [LVL_W-1:0] level,
    output logic             rising
);

    localparam logic [LVL_W-1:0] LO_V     = LVL_W'(LVL_LO);
    localparam logic [LVL_W-1:0] HI_V     = LVL_W'(LVL_HI);
    localparam logic [LVL_W-1:0] BEFORE_HI = LVL_W'(LVL_HI - 1);
    localparam logic [LVL_W-1:0] AFTER_LO  = LVL_W'(LVL_LO + 1);

    ramp_state_t state_q, state_d;

    // Next-state logic: turn on the step that lands on a bound.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RISE: if (step && (level == BEFORE_HI)) state_d = ST_FALL;
            ST_FALL: if (step && (level == AFTER_LO))  state_d = ST_RISE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RISE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: the brightness word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= LO_V;
        end else if (step) begin
            unique case (state_q)
                ST_RISE: level <= level + LVL_W'(1);
                ST_FALL: level <= level - LVL_W'(1);
            endcase
        end
    end

    assign rising = (state_q == ST_RISE);

    // R6: level stays inside its bounds
    a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (level >= LO_V) && (level <= HI_V));

    // R2: no enable, no movement
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(level));

    // R3: a rising step adds exactly one
    a_r3_unit_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rising) |=> (level == $past(level) + LVL_W'(1)));

    // R3: a falling step removes exactly one
    a_r3_unit_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !rising) |=> (level == $past(level) - LVL_W'(1)));

    // R4: at the upper bound the direction is already down
    a_r4_turn_at_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (level == HI_V) |-> !rising);

    // R5: at the lower bound the direction is up
    a_r5_turn_at_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LO_V) |-> rising);

endmodule

// File: rtl/breath_ramp.sv
module breath_ramp #(
    parameter int LVL_W  = 8,
    parameter int LVL_LO = 0,
    parameter int LVL_HI = 255,
    parameter int DIV_W  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] step_div,
    output logic [LVL_W-1:0] level,
    output logic             rising
);

    logic step_en;

    breath_tick #(
        .DIV_W (DIV_W)
    ) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_val (step_div),
        .tick    (step_en)
    );

    breath_seq #(
        .LVL_W  (LVL_W),
        .LVL_LO (LVL_LO),
        .LVL_HI (LVL_HI)
    ) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step_en),
        .level  (level),
        .rising (rising)
    );

endmodule

// File: tb/breath_ramp_tb.sv
`timescale 1ns/1ps
module breath_ramp_tb_top;

    localparam int LVL_W = 4;
    localparam int LO    = 2;
    localparam int HI    = 9;
    localparam int DIV_W = 4;
    localparam int SPAN  = HI - LO;
    localparam int PER   = 2 * SPAN;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] step_div = '0;
    logic [LVL_W-1:0] level;
    logic             rising;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    breath_ramp #(
        .LVL_W  (LVL_W),
        .LVL_LO (LO),
        .LVL_HI (HI),
        .DIV_W  (DIV_W)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_div (step_div),
        .level    (level),
        .rising   (rising)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_level(input int steps);
        int ph = steps % PER;
        return (ph <= SPAN) ? LO + ph : HI - (ph - SPAN);
    endfunction

    function automatic int exp_rising(input int steps);
        int ph = steps % PER;
        return (ph < SPAN) ? 1 : 0;
    endfunction

    function automatic string tag_for(input int steps, input int prev_steps);
        int ph = steps % PER;
        if (steps == prev_steps) return "R2 hold";
        if (ph == SPAN)          return "R4 upper turn";
        if (ph == 0)             return "R5 lower turn";
        if (steps > PER)         return "R7 repeat";
        return "R3 unit step";
    endfunction

    task automatic sweep(input int d);
        int ncyc;
        int prev;
        @(negedge clk);
        rst_n    = 1'b0;
        step_div = DIV_W'(d);
        @(posedge clk);
        @(negedge clk);
        // R1: reset values, including reset arriving mid-ramp
        check("R1 reset level", int'(level), LO);
        check("R1 reset rising", int'(rising), 1);
        rst_n = 1'b1;
        ncyc = (2 * PER + PER / 2) * (d + 1) + 2;
        prev = 0;
        for (int e = 1; e <= ncyc; e++) begin
            int st;
            @(posedge clk);
            @(negedge clk);
            st = (e - 1) / (d + 1);
            if (e <= d + 1) begin
                check("R1 cleared prescaler", int'(level), LO);
            end else begin
                check(tag_for(st, prev), int'(level), exp_level(st));
            end
            check((exp_level(st) == HI) ? "R4 direction" :
                  (exp_level(st) == LO) ? "R5 direction" : "R3 direction",
                  int'(rising), exp_rising(st));
            check("R6 range", int'((level >= LVL_W'(LO)) && (level <= LVL_W'(HI))), 1);
            prev = st;
        end
    endtask

    initial begin
        sweep(0);
        sweep(1);
        sweep(3);
        sweep(6);
        sweep(15);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule